// File: doc/BRIEF.md
# Chained Event Time Base

This block keeps a wide tick counter that serves as the event clock of one acquisition unit. Several units can be wired in a chain so that all of them count against one shared time base. A trigger strobe freezes the running count into a stamp register. Software later uses that stamp to rejoin events that were recorded by different units.

A mode input sets the role of the unit. As the head of the chain (master), the unit makes its own count-enable tick from a divider. On the first cycle after its local reset it also issues a one-cycle synchronous clear. It uses both itself and passes both down the chain. As a follower (slave), it takes the tick and the clear from the unit above it and counts on them. In both roles the tick and the clear going down are registered once, so each hop adds one fixed cycle of latency. A follower k hops from the head therefore holds the head's count delayed by exactly k cycles.

Top module: `timebase_link`

## Requirements
- R1: With default parameters the counter is 40 bits wide, and in master mode it advances on every clock cycle (one step per 10 ns at 100 MHz).
- R2: In master mode the local tick is asserted on one cycle out of every TICK_DIV, first on cycle TICK_DIV-1 after reset release (cycle 0 is the first edge after release). The upstream tick and clear inputs have no effect in this mode.
- R3: In master mode a single clear pulse is issued on cycle 0 after reset release, and no further clear is issued until the next reset.
- R4: In slave mode the counter is driven by up_tick and up_sync_clr, both sampled on the same clock edge that updates the counter.
- R5: dn_tick and dn_sync_clr equal the local tick and clear of the previous cycle, in both modes.
- R6: A clear sets the counter to zero on the edge where it is seen, and it takes priority over a tick on that same edge.
- R7: A tick with the counter at all ones wraps the counter to zero without a stall. wrap is high for exactly the one cycle after that edge.
- R8: On a rising edge of trig (high now, low on the previous edge), stamp takes the counter value from before that edge's update. At all other times stamp holds its value, including while trig stays high.
- R9: While rst_n is low, stamp, wrap, dn_tick and dn_sync_clr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low local reset |
| is_master | input | 1 | 1 = head of chain, 0 = follower |
| up_tick | input | 1 | Count-enable from the unit above |
| up_sync_clr | input | 1 | Synchronous clear from the unit above |
| trig | input | 1 | Trigger strobe, latched on its rising edge |
| dn_tick | output | 1 | Registered count-enable toward the unit below |
| dn_sync_clr | output | 1 | Registered clear toward the unit below |
| stamp | output | CNT_W | Count captured at the last trigger rising edge |
| wrap | output | 1 | One-cycle pulse after the counter rolls over |

## Verification
The counter is internal, so a wrong count shows up only in stamp, on the first rising edge of trig that follows the fault, and as a wrap pulse that comes early or late. A mistake in tick or clear selection shows on dn_tick and dn_sync_clr one cycle later. The bench fires triggers densely, every few cycles, so a drifted count becomes visible within a handful of cycles. Running a narrow counter through full wrap periods in both modes covers every count value that is reachable.

// File: rtl/timebase_link.sv
module timebase_link #(
  parameter int CNT_W    = 40,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             up_tick,
  input  logic             up_sync_clr,
  input  logic             trig,
  output logic             dn_tick,
  output logic             dn_sync_clr,
  output logic [CNT_W-1:0] stamp,
  output logic             wrap
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gen_tick, started, trig_q;
  logic             loc_tick, loc_clr, trig_rise;
  logic [CNT_W-1:0] cnt;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign gen_tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_cnt;
      assign gen_tick = (div_cnt == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        div_cnt <= '0;
        else if (gen_tick) div_cnt <= '0;
        else               div_cnt <= div_cnt + 1'b1;
    end
  endgenerate

  assign loc_tick  = is_master ? gen_tick : up_tick;
  assign loc_clr   = is_master ? ~started : up_sync_clr;
  assign trig_rise = trig & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      trig_q      <= 1'b0;
      dn_tick     <= 1'b0;
      dn_sync_clr <= 1'b0;
      cnt         <= '0;
      stamp       <= '0;
      wrap        <= 1'b0;
    end else begin
      started     <= 1'b1;
      trig_q      <= trig;
      dn_tick     <= loc_tick;
      dn_sync_clr <= loc_clr;
      wrap        <= loc_tick & ~loc_clr & (cnt == CNT_MAX);
      if (trig_rise) stamp <= cnt;
      if (loc_clr)       cnt <= '0;
      else if (loc_tick) cnt <= cnt + 1'b1;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    loc_clr |=> (cnt == '0)); // R6
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_tick && !loc_clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_tick && !loc_clr) |=> $stable(cnt)); // R4
  AST_WRAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap); // R7
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig && !trig_q) |=> $stable(stamp)); // R8
  AST_HOP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master) |=> (dn_tick == $past(up_tick) && dn_sync_clr == $past(up_sync_clr))); // R5
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && started) |-> !loc_clr); // R3
endmodule

// File: tb/timebase_link_test.sv
module timebase_link_test;
  localparam int W   = 6;
  localparam int DIV = 2;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 0, rst_n = 0, is_master = 1;
  logic up_tick = 0, up_sync_clr = 0, trig = 0;
  logic dn_tick, dn_sync_clr, wrap, f_dn_tick, f_dn_clr, f_wrap;
  logic [W-1:0]  stamp;
  logic [39:0]   f_stamp;

  int total = 0, bad = 0, j = 0;
  logic [W-1:0]  cnt_m, stamp_m;
  logic [39:0]   cnt_f, stamp_f;
  logic          trig_prev;
  bit            done = 0;

  always #5 clk = ~clk;

  timebase_link #(.CNT_W(W), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .up_tick(up_tick),
    .up_sync_clr(up_sync_clr), .trig(trig), .dn_tick(dn_tick),
    .dn_sync_clr(dn_sync_clr), .stamp(stamp), .wrap(wrap));

  timebase_link uut_fast (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .up_tick(up_tick),
    .up_sync_clr(up_sync_clr), .trig(trig), .dn_tick(f_dn_tick),
    .dn_sync_clr(f_dn_clr), .stamp(f_stamp), .wrap(f_wrap));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at j=%0d", req, act, exp, j);
    end
  endtask

  task automatic do_reset(input logic master);
    rst_n = 0; is_master = master; trig = 0; up_tick = 0; up_sync_clr = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R9 stamp", 64'(stamp), 0);
    check("R9 wrap", 64'(wrap), 0);
    check("R9 dn_tick", 64'(dn_tick), 0);
    check("R9 dn_sync_clr", 64'(dn_sync_clr), 0);
    @(negedge clk);
    rst_n = 1; j = 0; cnt_m = 0; stamp_m = 0; cnt_f = 0; stamp_f = 0; trig_prev = 0;
  endtask

  task automatic step(input logic trg, input logic ut, input logic uc);
    logic t, c, rise, wrap_e;
    trig = trg; up_tick = ut; up_sync_clr = uc;
    if (is_master) begin
      t = ((j % DIV) == DIV - 1);
      c = (j == 0);
    end else begin
      t = ut; c = uc;
    end
    rise = trg && !trig_prev;
    if (rise) begin
      stamp_m = cnt_m;
      stamp_f = cnt_f;
    end
    wrap_e = t && !c && (cnt_m == MAXV);
    if (c) cnt_m = 0; else if (t) cnt_m = cnt_m + 1'b1;
    if (j == 0) cnt_f = 0; else cnt_f = cnt_f + 1;
    trig_prev = trg;
    @(posedge clk);
    #1;
    check(is_master ? "R2 dn_tick" : "R5 dn_tick", 64'(dn_tick), 64'(t));
    check(is_master ? "R3 dn_sync_clr" : "R4 dn_sync_clr", 64'(dn_sync_clr), 64'(c));
    check("R8 stamp", 64'(stamp), 64'(stamp_m));
    check("R7 wrap", 64'(wrap), 64'(wrap_e));
    if (rise) check("R6 stamp after clear/tick", 64'(stamp), 64'(stamp_m));
    check("R1 fast stamp", 64'(f_stamp), 64'(stamp_f));
    check("R1 fast dn_tick", 64'(f_dn_tick), 1);
    @(negedge clk);
    j++;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    for (int i = 0; i < 300; i++)
      step((i % 7) < 3, (i % 2) == 1, (i % 5) == 0);
    do_reset(1'b0);
    for (int i = 0; i < 260; i++)
      step((i % 11) < 5 || (i > 200 && i < 215), (i % 4) != 3,
           i == 90 || i == 150 || i == 151 || i == 230);
    for (int i = 0; i < 140; i++)
      step((i % 3) == 0, 1'b1, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule